// File: doc/BRIEF.md
# Credit-Gated Transaction Issue Arbiter

The arbiter sits between an ordered queue of outgoing transactions and the link transmitter. It decides which queued transaction is sent next, based on the credits the link partner has advertised. Each transaction belongs to one of three traffic classes: posted, non-posted or completion. The block keeps a header credit limit and a data credit limit for each class, together with matching consumed counters. A credit message either loads a fresh advertisement, which clears the consumed counters, or raises the limit of one class.

In each cycle the oldest transaction whose class has enough header and data credits is chosen. It needs one header credit, plus one data credit per started group of four doublewords. It is removed from the queue, its credits are deducted in the same cycle, and it moves into a one-entry issue slot. There is a single exception to strict age order. When the oldest entry is a non-posted request that is waiting for credits, the first entry behind the run of waiting non-posted requests may go ahead of them, but only if it is a posted write. A completion or a posted write that lacks credits never overtakes anything.

Both data edges use valid/ready. An input transaction is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low only while the queue holds `DEPTH` entries. The issue slot raises `out_valid` and keeps its payload unchanged until a cycle with `out_ready` high. The credit inputs are plain control pins, sampled on any cycle with `cr_valid` high.

Top module: `cga_issue_arbiter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every limit and consumed counter is 0, so nothing issues until credits are advertised.
- R2: A transaction is taken when `in_valid` and `in_ready` are both high. `in_ready` is 0 exactly when `DEPTH` entries are queued. The class encoding is 0 = posted, 1 = non-posted and 2 = completion.
- R3: A transaction issues only if its class has both a free header credit and free data credits. It needs 1 header credit and ceil(dw/4) data credits. Credits are free when (limit − consumed − need), taken modulo 2^W, is no greater than 2^(W−1). W is 8 for header counters and 12 for data counters.
- R4: A credit message with `cr_init`=1 loads both limits of class `cr_kind` and clears both of its consumed counters. This takes priority over a deduction in the same cycle. With `cr_init`=0 the message loads the limits only. A held transaction issues once enough credits are free.
- R5: When the oldest queued transaction has credits, it is the one issued.
- R6: Suppose the oldest entry is non-posted and lacks credits. The first entry behind the run of non-posted entries is then issued if it is posted and has credits. The non-posted request stays oldest and issues once its credits return.
- R7: A completion never overtakes an older entry. A non-posted request never overtakes an older posted write. Posted writes issue in their arrival order.
- R8: At most one transaction is selected per cycle, and its credits are deducted in that cycle. The selected transaction appears on `out_*` in the next cycle. `out_valid` and the payload hold until `out_ready` is high.
- R9: Consumed counters wrap modulo 2^W. Issue stays correct across many wraps, and a limit equal to the consumed value grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction valid |
| in_ready | output | 1 | Queue can take a transaction |
| in_kind | input | 2 | Class: 0 posted, 1 non-posted, 2 completion |
| in_dw | input | DW_W | Payload length in doublewords (0 = no data) |
| in_tag | input | TAG_W | Opaque identifier carried to the output |
| cr_valid | input | 1 | Credit message present |
| cr_init | input | 1 | 1 = initial advertisement, 0 = update |
| cr_kind | input | 2 | Class the message refers to |
| cr_hdr | input | HDR_W | Header credit limit |
| cr_dat | input | DAT_W | Data credit limit |
| out_valid | output | 1 | Issued transaction present |
| out_ready | input | 1 | Transmitter takes the issued transaction |
| out_kind | output | 2 | Class of issued transaction |
| out_dw | output | DW_W | Length of issued transaction |
| out_tag | output | TAG_W | Identifier of issued transaction |

## Verification
The first directed pattern queues posted writes with no credits, then advertises a few header credits and afterwards a larger limit. This separates holding back from issuing, and an initial advertisement from an update. Mixed queues follow, in which a non-posted request waits at the head with a completion, posted writes or further non-posted requests behind it. These show whether only a posted write bypasses, whether completions and non-posted requests stay behind, and whether the bypassed request issues once its credits return. Long runs of maximum-length writes drive the header and data counters through many wraps and also stop at exact credit boundaries. A random phase mixes classes, lengths, credit trickles and output stalls, and is compared cycle by cycle against a behavioural queue model.

// File: rtl/cga_pkg.sv
package cga_pkg;
  typedef enum logic [1:0] {
    K_POST    = 2'd0,
    K_NONPOST = 2'd1,
    K_CPL     = 2'd2
  } kind_e;

  localparam int NKIND = 3;
endpackage

// File: rtl/cga_order_queue.sv
// Age-ordered queue whose entries can be taken from any position; the
// entries above a removed one slide down by one place, so index 0 is oldest.
module cga_order_queue #(
  parameter int DEPTH = 8,
  parameter int EW    = 20,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_ent,
  input  logic          pop,
  input  logic [IW-1:0] pop_idx,
  output logic [EW-1:0] ent [DEPTH],
  output logic [CW-1:0] count
);
  logic [EW-1:0] slots_q [DEPTH];
  logic [EW-1:0] slots_d [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_after;

  always_comb begin
    cnt_after = cnt_q - CW'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      slots_d[i] = slots_q[i];
      if (pop && IW'(i) >= pop_idx && i < DEPTH - 1) slots_d[i] = slots_q[i+1];
      if (push && cnt_after == CW'(i)) slots_d[i] = push_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
    end else begin
      cnt_q <= cnt_after + CW'(push);
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= slots_d[i];
    end
  end

  assign ent   = slots_q;
  assign count = cnt_q;

  // R2: no write into a full queue
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < CW'(DEPTH));

  // R5: removals only name occupied positions
  assert_pop_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> {1'b0, pop_idx} < (IW+1)'(cnt_q));
endmodule

// File: rtl/cga_credit_bank.sv
// Per-class header/data credit limits and consumed counters, with the
// modulo half-range test for three independent credit queries.
module cga_credit_bank #(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int UW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cr_valid,
  input  logic             cr_init,
  input  logic [1:0]       cr_kind,
  input  logic [HDR_W-1:0] cr_hdr,
  input  logic [DAT_W-1:0] cr_dat,
  input  logic [1:0]       h_kind,
  input  logic [UW-1:0]    h_units,
  output logic             h_ok,
  input  logic [1:0]       b_kind,
  input  logic [UW-1:0]    b_units,
  output logic             b_ok,
  input  logic             take,
  input  logic [1:0]       take_kind,
  input  logic [UW-1:0]    take_units
);
  import cga_pkg::*;

  localparam logic [HDR_W-1:0] HALF_H = HDR_W'(1) << (HDR_W - 1);
  localparam logic [DAT_W-1:0] HALF_D = DAT_W'(1) << (DAT_W - 1);

  function automatic logic fits(logic [HDR_W-1:0] lh, logic [HDR_W-1:0] uh,
                                logic [DAT_W-1:0] ld, logic [DAT_W-1:0] ud,
                                logic [UW-1:0] units);
    logic [HDR_W-1:0] dh;
    logic [DAT_W-1:0] dd;
    dh = lh - uh - HDR_W'(1);
    dd = ld - ud - DAT_W'(units);
    return (dh <= HALF_H) && (dd <= HALF_D);
  endfunction

  logic [3:0] okh_v, okb_v, okt_v;
  assign okh_v[3] = 1'b0;
  assign okb_v[3] = 1'b0;
  assign okt_v[3] = 1'b0;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    logic [HDR_W-1:0] lim_h, use_h;
    logic [DAT_W-1:0] lim_d, use_d;
    logic             load, clear, spend;

    assign load  = cr_valid && cr_kind == 2'(k);
    assign clear = load && cr_init;
    assign spend = take && take_kind == 2'(k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_h <= '0;
        lim_d <= '0;
        use_h <= '0;
        use_d <= '0;
      end else begin
        if (load) begin
          lim_h <= cr_hdr;
          lim_d <= cr_dat;
        end
        if (clear) begin
          use_h <= '0;
          use_d <= '0;
        end else if (spend) begin
          use_h <= use_h + HDR_W'(1);
          use_d <= use_d + DAT_W'(take_units);
        end
      end
    end

    assign okh_v[k] = fits(lim_h, use_h, lim_d, use_d, h_units);
    assign okb_v[k] = fits(lim_h, use_h, lim_d, use_d, b_units);
    assign okt_v[k] = fits(lim_h, use_h, lim_d, use_d, take_units);
  end

  assign h_ok = okh_v[h_kind];
  assign b_ok = okb_v[b_kind];

  // R3: the selector never spends credits the partner has not granted
  assert_take_has_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> okt_v[take_kind]);
endmodule

// File: rtl/cga_pick.sv
// Chooses the head entry, or the single posted write allowed to pass a run
// of waiting non-posted requests.
module cga_pick #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          en,
  input  logic [CW-1:0] count,
  input  logic [1:0]    kinds [DEPTH],
  input  logic          head_ok,
  input  logic          byp_ok,
  output logic [IW-1:0] byp_idx,
  output logic          sel_v,
  output logic [IW-1:0] sel_idx
);
  import cga_pkg::*;

  logic found;
  logic byp_cand;

  always_comb begin
    found   = 1'b0;
    byp_idx = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (!found && CW'(i) < count && kinds[i] != K_NONPOST) begin
        found   = 1'b1;
        byp_idx = IW'(i);
      end
    end
  end

  assign byp_cand = count != '0 && kinds[0] == K_NONPOST && found &&
                    kinds[byp_idx] == K_POST;

  always_comb begin
    sel_v   = 1'b0;
    sel_idx = '0;
    if (en && count != '0) begin
      if (head_ok) begin
        sel_v = 1'b1;
      end else if (byp_cand && byp_ok) begin
        sel_v   = 1'b1;
        sel_idx = byp_idx;
      end
    end
  end
endmodule

// File: rtl/cga_issue_arbiter.sv
module cga_issue_arbiter #(
  parameter int DEPTH = 8,
  parameter int DW_W  = 10,
  parameter int TAG_W = 8,
  parameter int HDR_W = 8,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [DW_W-1:0]  in_dw,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             cr_valid,
  input  logic             cr_init,
  input  logic [1:0]       cr_kind,
  input  logic [HDR_W-1:0] cr_hdr,
  input  logic [DAT_W-1:0] cr_dat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [DW_W-1:0]  out_dw,
  output logic [TAG_W-1:0] out_tag
);
  import cga_pkg::*;

  localparam int EW = TAG_W + DW_W + 2;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int UW = DW_W - 1;

  function automatic logic [UW-1:0] units_of(logic [DW_W-1:0] dw);
    logic [DW_W:0] s;
    s = {1'b0, dw} + (DW_W+1)'(3);
    return s[DW_W:2];
  endfunction

  logic [EW-1:0] ent [DEPTH];
  logic [1:0]    kinds [DEPTH];
  logic [CW-1:0] count;
  logic          push;
  logic [IW-1:0] byp_idx, sel_idx;
  logic          sel_v, h_ok, b_ok, slot_free;
  logic [EW-1:0] sel_e, slot_e;
  logic          slot_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_kinds
    assign kinds[i] = ent[i][1:0];
  end

  assign in_ready  = count < CW'(DEPTH);
  assign push      = in_valid && in_ready;
  assign slot_free = !slot_v || out_ready;
  assign sel_e     = ent[sel_idx];

  cga_order_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_ent ({in_tag, in_dw, in_kind}),
    .pop      (sel_v),
    .pop_idx  (sel_idx),
    .ent      (ent),
    .count    (count)
  );

  cga_credit_bank #(.HDR_W(HDR_W), .DAT_W(DAT_W), .UW(UW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cr_valid   (cr_valid),
    .cr_init    (cr_init),
    .cr_kind    (cr_kind),
    .cr_hdr     (cr_hdr),
    .cr_dat     (cr_dat),
    .h_kind     (kinds[0]),
    .h_units    (units_of(ent[0][DW_W+1:2])),
    .h_ok       (h_ok),
    .b_kind     (kinds[byp_idx]),
    .b_units    (units_of(ent[byp_idx][DW_W+1:2])),
    .b_ok       (b_ok),
    .take       (sel_v),
    .take_kind  (sel_e[1:0]),
    .take_units (units_of(sel_e[DW_W+1:2]))
  );

  cga_pick #(.DEPTH(DEPTH)) u_pick (
    .en      (slot_free),
    .count   (count),
    .kinds   (kinds),
    .head_ok (h_ok),
    .byp_ok  (b_ok),
    .byp_idx (byp_idx),
    .sel_v   (sel_v),
    .sel_idx (sel_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= 1'b0;
      slot_e <= '0;
    end else if (sel_v) begin
      slot_v <= 1'b1;
      slot_e <= sel_e;
    end else if (out_ready) begin
      slot_v <= 1'b0;
    end
  end

  assign out_valid = slot_v;
  assign out_kind  = slot_e[1:0];
  assign out_dw    = slot_e[DW_W+1:2];
  assign out_tag   = slot_e[EW-1:DW_W+2];

  // R8: a stalled issue keeps its payload
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) &&
                                $stable(out_dw) && $stable(out_tag));

  // R6, R7: only a posted write leaves from behind a waiting non-posted head
  assert_only_posted_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_v && sel_idx != '0 |-> sel_e[1:0] == K_POST && kinds[0] == K_NONPOST);
endmodule

// File: tb/cga_issue_arbiter_bench.sv
module cga_issue_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, DW_W = 10, TAG_W = 8, HDR_W = 8, DAT_W = 12;
  localparam int HM = (1 << HDR_W) - 1, DM = (1 << DAT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, cr_valid = 0, cr_init = 0, out_ready = 1;
  logic [1:0] in_kind = 0, cr_kind = 0;
  logic [DW_W-1:0] in_dw = 0;
  logic [TAG_W-1:0] in_tag = 0;
  logic [HDR_W-1:0] cr_hdr = 0;
  logic [DAT_W-1:0] cr_dat = 0;
  logic in_ready, out_valid;
  logic [1:0] out_kind;
  logic [DW_W-1:0] out_dw;
  logic [TAG_W-1:0] out_tag;

  cga_issue_arbiter u_cga_issue_arbiter (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string phase = "R1";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference
  typedef struct { int kind; int dw; int tag; } ent_t;
  ent_t mq[$];
  bit   m_sv;
  ent_t m_se;
  int   m_lh[3], m_uh[3], m_ld[3], m_ud[3];

  function automatic int need_of(int dw); return (dw + 3) / 4; endfunction
  function automatic bit fits_m(ent_t e);
    int dh, dd;
    dh = (m_lh[e.kind] - m_uh[e.kind] - 1) & HM;
    dd = (m_ld[e.kind] - m_ud[e.kind] - need_of(e.dw)) & DM;
    return dh <= (HM + 1) / 2 && dd <= (DM + 1) / 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_sv = 0;
      for (int k = 0; k < 3; k++) begin m_lh[k] = 0; m_uh[k] = 0; m_ld[k] = 0; m_ud[k] = 0; end
    end else begin
      bit rdy, free;
      int sel, j;
      rdy = mq.size() < DEPTH;
      free = !m_sv || out_ready;
      sel = -1;
      if (free && mq.size() > 0) begin
        if (fits_m(mq[0])) sel = 0;
        else if (mq[0].kind == 1) begin
          j = -1;
          for (int i = 1; i < mq.size(); i++) if (j < 0 && mq[i].kind != 1) j = i;
          if (j > 0 && mq[j].kind == 0 && fits_m(mq[j])) sel = j;
        end
      end
      if (sel >= 0) begin
        m_sv = 1; m_se = mq[sel];
        m_uh[m_se.kind] = (m_uh[m_se.kind] + 1) & HM;
        m_ud[m_se.kind] = (m_ud[m_se.kind] + need_of(m_se.dw)) & DM;
        mq.delete(sel);
      end else if (m_sv && out_ready) m_sv = 0;
      if (in_valid && rdy) begin
        ent_t e; e.kind = in_kind; e.dw = in_dw; e.tag = in_tag; mq.push_back(e);
      end
      if (cr_valid && cr_kind < 3) begin
        m_lh[cr_kind] = cr_hdr; m_ld[cr_kind] = cr_dat;
        if (cr_init) begin m_uh[cr_kind] = 0; m_ud[cr_kind] = 0; end
      end
    end
  end

  int iss[$];
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " out_valid"}, out_valid, m_sv);
      chk({phase, " in_ready"}, in_ready, mq.size() < DEPTH);
      if (out_valid && m_sv) begin
        chk({phase, " out_tag"}, out_tag, m_se.tag);
        chk({phase, " out_kind"}, out_kind, m_se.kind);
        chk({phase, " out_dw"}, out_dw, m_se.dw);
      end
      if (out_valid && out_ready) iss.push_back(out_tag);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(int n); repeat (n) step(); endtask

  task automatic push(int kind, int dw, int tag);
    bit r;
    in_valid = 1; in_kind = 2'(kind); in_dw = DW_W'(dw); in_tag = TAG_W'(tag);
    do begin r = in_ready; step(); end while (!r);
    in_valid = 0;
  endtask

  task automatic credit(bit init, int kind, int hdr, int dat);
    cr_valid = 1; cr_init = init; cr_kind = 2'(kind);
    cr_hdr = HDR_W'(hdr & HM); cr_dat = DAT_W'(dat & DM);
    step();
    cr_valid = 0; cr_init = 0;
  endtask

  task automatic expect_tags(string req, int exp[$]);
    chk({req, " issue count"}, iss.size(), exp.size());
    foreach (exp[i]) if (i < iss.size()) chk({req, " issue order"}, iss[i], exp[i]);
    iss.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    #(CLK_PERIOD/2);
    chk("R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    step();
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);

    // R2 / R3: fill with no credits
    phase = "R2";
    for (int i = 1; i <= DEPTH; i++) push(0, 16, i);
    chk("R2 full queue in_ready", in_ready, 0);
    phase = "R3";
    idle(5);
    chk("R3 no credits no issue", out_valid, 0);
    expect_tags("R3", '{});
    phase = "R4";
    credit(1, 0, 3, 100);
    idle(8);
    expect_tags("R4 init grants three", '{1, 2, 3});
    credit(0, 0, 8, 100);
    idle(10);
    expect_tags("R5 update releases rest", '{4, 5, 6, 7, 8});

    // R6 / R7 ordering
    phase = "R7";
    credit(0, 0, 28, 200);
    credit(1, 1, 0, 0);
    credit(1, 2, 10, 200);
    push(1, 0, 20); push(2, 8, 21); push(0, 4, 22);
    idle(6);
    expect_tags("R7 completion does not bypass", '{});
    credit(0, 1, 1, 0);
    idle(8);
    expect_tags("R7 release in age order", '{20, 21, 22});
    phase = "R6";
    push(1, 0, 30); push(0, 4, 31); push(0, 4, 32); push(1, 0, 33); push(0, 4, 34);
    idle(8);
    expect_tags("R6 posted bypass", '{31, 32, 34});
    credit(0, 1, 3, 0);
    idle(8);
    expect_tags("R6 waiting reads follow", '{30, 33});
    phase = "R7";
    credit(0, 1, 5, 0);
    credit(0, 0, m_uh[0], m_ud[0] + 100);
    push(0, 4, 40); push(1, 0, 41);
    idle(6);
    expect_tags("R7 read stays behind posted", '{});
    credit(0, 0, m_uh[0] + 5, m_ud[0] + 100);
    idle(6);
    expect_tags("R7 posted then read", '{40, 41});

    // R8 stall
    phase = "R8";
    out_ready = 0;
    push(0, 4, 50); push(0, 4, 51);
    idle(6);
    chk("R8 held valid", out_valid, 1);
    chk("R8 held tag", out_tag, 50);
    out_ready = 1;
    idle(5);
    expect_tags("R8 drained", '{50, 51});

    // R4 init clears consumed, R9 wrap
    phase = "R4";
    credit(1, 0, 2, 100);
    push(0, 4, 60); push(0, 4, 61); push(0, 4, 62);
    idle(6);
    expect_tags("R4 init clears consumed", '{60, 61});
    credit(0, 0, 3, 100);
    idle(4);
    expect_tags("R4 update adds one", '{62});
    phase = "R9";
    for (int i = 0; i < 300; i++) begin
      push(0, 1020, i & 255);
      credit(0, 0, m_uh[0] + 3, m_ud[0] + 600);
    end
    idle(6);
    chk("R9 wrapped issue count", iss.size(), 300);
    iss.delete();
    credit(0, 0, m_uh[0], m_ud[0] + 600);
    push(0, 0, 70);
    idle(5);
    chk("R9 equal limit grants nothing", out_valid, 0);
    credit(0, 0, m_uh[0] + 2, m_ud[0] + 254);
    push(0, 1020, 71);
    idle(4);
    expect_tags("R9 header freed", '{70});
    idle(3);
    expect_tags("R3 data short", '{});
    credit(0, 0, m_uh[0] + 2, m_ud[0] + 255);
    idle(4);
    expect_tags("R3 data exact", '{71});

    // random mix
    phase = "R5 random";
    for (int c = 0; c < 3000; c++) begin
      int k;
      in_valid = ($urandom % 2) == 0;
      in_kind = 2'($urandom % 3);
      in_dw = DW_W'($urandom % 64);
      in_tag = TAG_W'($urandom);
      out_ready = ($urandom % 4) != 0;
      cr_valid = ($urandom % 4) == 0;
      k = $urandom % 3;
      cr_kind = 2'(k);
      cr_hdr = HDR_W'((m_uh[k] + $urandom % 4) & HM);
      cr_dat = DAT_W'((m_ud[k] + $urandom % 40) & DM);
      step();
    end
    in_valid = 0; cr_valid = 0; out_ready = 1;
    for (int k = 0; k < 3; k++) credit(0, k, m_uh[k] + 100, m_ud[k] + 1000);
    idle(30);
    chk("R8 drained at end", out_valid, 0);
    chk("R2 empty at end", in_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule